// File: doc/BRIEF.md
# Buffered Baud Divisor Generator

This block generates the oversample tick for a serial port from a 13-bit programmable divisor. Software loads the divisor through two byte-wide registers, an upper one and a lower one. A write to the upper register only stages its divisor bits. The following write to the lower register moves the staged bits and the new low byte into the working divisor on the same clock edge. The divider therefore never runs with half of an old value and half of a new one.

The upper register also holds two interrupt-enable flags. These take effect as soon as they are written and are offered to neighbouring logic as outputs. The divider stays silent after reset until the receive or transmit enable is first seen high. From then on it runs until the next reset. While it runs, it produces one single-cycle tick every `divisor` clock cycles. A divisor of zero stops the ticks.

Top module: `baud_div_gen`

## Requirements
- R1: The working divisor is 13 bits wide. Its bits 12:8 come from upper-register bits 4:0 and its bits 7:0 from the lower register. With a non-zero divisor D, a tick occurs exactly once in every D clock cycles.
- R2: A write to the upper register (wr_sel = 0) changes only the staging buffer for the divisor bits. The working divisor, the upper-register readback field and the tick rate stay the same until the lower register is written.
- R3: A write to the lower register (wr_sel = 1) loads the working divisor with {staged upper bits, written byte} in one clock edge. A lower write with no upper write in between uses the most recently staged bits again.
- R4: After reset, the lower register reads 0x04, the upper register reads 0x00 and tick is low.
- R5: No tick occurs after reset until rx_en or tx_en has been high at a clock edge. Either enable alone is enough to start the divider.
- R6: Once started, the divider keeps ticking after both enables return low. Only reset stops it.
- R7: Upper-register layout: bit 7 is the break-detect interrupt enable, bit 6 is the receive-edge interrupt enable, bit 5 always reads 0, and bits 4:0 read the working divisor bits, not the staged ones. The two enable bits appear on brk_ie and rxe_ie from the edge after the write.
- R8: While the working divisor is zero, tick stays low. Ticks resume after a non-zero divisor is committed.
- R9: A lower-register write restarts the count. If the write is taken at edge m and the new divisor is D, the first tick is high in the cycle after edge m+D-1, and the following ticks come every D cycles.
- R10: Tick is high for one cycle only when D > 1, and high in every cycle when D = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 upper register, 1 lower register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 upper register, 1 lower register |
| rd_data | output | 8 | Combinational readback of the selected register |
| rx_en | input | 1 | Receiver enable, starts the divider |
| tx_en | input | 1 | Transmitter enable, starts the divider |
| brk_ie | output | 1 | Break-detect interrupt enable flag |
| rxe_ie | output | 1 | Receive-edge interrupt enable flag |
| tick | output | 1 | Single-cycle oversample tick |

## Verification
The assertions check on every cycle that:
- the working divisor holds across upper-register writes;
- a lower-register write produces exactly the staged-plus-written value;
- the reserved bit reads zero;
- no tick appears before the first enable or with a zero divisor;
- ticks never come back to back for divisors above one.

The exact tick phase after a commit, the period across a sweep of divisors up to the 13-bit maximum, the reset values, and the divider continuing to run after the enables drop can be shown only by the bench's scenarios. The bench works out its expected tick positions from the divisor and the commit cycle.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
    localparam int BYTE_W  = 8;
    localparam int BRK_BIT = 7;
    localparam int RXE_BIT = 6;
    localparam int RSV_BIT = 5;

    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/bdg_regs.sv
module bdg_regs
    import bdg_pkg::*;
#(
    parameter int          DIV_W  = 13,
    parameter logic [7:0]  LO_RST = 8'h04
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   rd_sel,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [DIV_W-1:0]       work_div,
    output logic [DIV_W-BYTE_W-1:0] staged,
    output logic                   load,
    output logic [DIV_W-1:0]       load_div,
    output logic                   brk_ie,
    output logic                   rxe_ie
);
    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]   stage;
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
        logic              brk;
        logic              rxe;
    } regs_t;

    regs_t st_d, st_q;
    logic  hi_wr, lo_wr;

    always_comb begin
        hi_wr = wr_en && (wr_sel == SEL_HI);
        lo_wr = wr_en && (wr_sel == SEL_LO);
        st_d  = st_q;
        if (hi_wr) begin
            st_d.stage = wr_data[HI_W-1:0];
            st_d.brk   = wr_data[BRK_BIT];
            st_d.rxe   = wr_data[RXE_BIT];
        end
        if (lo_wr) begin
            st_d.hi = st_q.stage;
            st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: '0, hi: '0, lo: LO_RST, brk: 1'b0, rxe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // readback: working value only, reserved bits zero
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_HI) begin
            rd_data[BRK_BIT]  = st_q.brk;
            rd_data[RXE_BIT]  = st_q.rxe;
            rd_data[HI_W-1:0] = st_q.hi;
        end else begin
            rd_data = st_q.lo;
        end
    end

    assign work_div = {st_q.hi, st_q.lo};
    assign staged   = st_q.stage;
    assign load     = lo_wr;
    assign load_div = {st_q.stage, wr_data};
    assign brk_ie   = st_q.brk;
    assign rxe_ie   = st_q.rxe;
endmodule

// File: rtl/bdg_start.sv
module bdg_start (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic tx_en,
    output logic started
);
    typedef struct packed {
        logic run;
    } start_t;

    start_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rx_en || tx_en) begin
            s_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign started = s_q.run;
endmodule

// File: rtl/bdg_divider.sv
module bdg_divider #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic [DIV_W-1:0] load_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t c_d, c_q;
    logic active;

    always_comb begin
        active = run && (div != '0);
        c_d    = c_q;
        if (load) begin
            c_d.cnt = load_div;
        end else if (!active) begin
            c_d.cnt = div;
        end else if (c_q.cnt <= ONE) begin
            c_d.cnt = div;
        end else begin
            c_d.cnt = c_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{cnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign tick = active && (c_q.cnt == ONE);
endmodule

// File: rtl/baud_div_gen.sv
module baud_div_gen #(
    parameter int         DIV_W  = 13,
    parameter logic [7:0] LO_RST = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    input  logic       rx_en,
    input  logic       tx_en,
    output logic       brk_ie,
    output logic       rxe_ie,
    output logic       tick
);
    localparam int HI_W = DIV_W - 8;

    logic [DIV_W-1:0] work_div;
    logic [HI_W-1:0]  staged;
    logic             load;
    logic [DIV_W-1:0] load_div;
    logic             started;

    bdg_regs #(.DIV_W(DIV_W), .LO_RST(LO_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .work_div (work_div),
        .staged   (staged),
        .load     (load),
        .load_div (load_div),
        .brk_ie   (brk_ie),
        .rxe_ie   (rxe_ie)
    );

    bdg_start u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .tx_en   (tx_en),
        .started (started)
    );

    bdg_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (started),
        .div      (work_div),
        .load     (load),
        .load_div (load_div),
        .tick     (tick)
    );
endmodule

// File: rtl/bdg_checker.sv
module bdg_checker #(
    parameter int DIV_W = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    wr_sel,
    input logic [7:0]              wr_data,
    input logic                    rd_sel,
    input logic [7:0]              rd_data,
    input logic                    rx_en,
    input logic                    tx_en,
    input logic [DIV_W-1:0]        work_div,
    input logic [DIV_W-8-1:0]      staged,
    input logic                    tick
);
    logic en_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_seen <= 1'b0;
        end else if (rx_en || tx_en) begin
            en_seen <= 1'b1;
        end
    end

    p_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> $stable(work_div));

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (work_div == {$past(staged), $past(wr_data)}));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_seen |-> !tick);

    p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |-> (rd_data[5] == 1'b0));

    p_zero_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (work_div == '0) |-> !tick);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && work_div > DIV_W'(1) && !wr_en) |=> !tick);
endmodule

bind baud_div_gen bdg_checker #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .work_div (work_div),
    .staged   (staged),
    .tick     (tick)
);

// File: tb/baud_div_gen_test.sv
module baud_div_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       rx_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_ie, rxe_ie, tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the register state, from the requirements
    logic [4:0] m_stage, m_hi;
    logic [7:0] m_lo;
    logic       m_brk, m_rxe;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_div_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .rx_en(rx_en), .tx_en(tx_en), .brk_ie(brk_ie), .rxe_ie(rxe_ie),
        .tick(tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_en = 1'b0; tx_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_stage = '0; m_hi = '0; m_lo = 8'h04; m_brk = 1'b0; m_rxe = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) begin
            m_stage = data[4:0]; m_brk = data[7]; m_rxe = data[6];
        end else begin
            m_hi = m_stage; m_lo = data;
        end
    endtask

    task automatic rd_check(input string req);
        rd_sel = 1'b0; #1;
        check(req, rd_data, {m_brk, m_rxe, 1'b0, m_hi});
        rd_sel = 1'b1; #1;
        check(req, rd_data, m_lo);
    endtask

    // starts at the negedge right after the commit edge
    task automatic run_window(input int d, input int w, input string req);
        for (int j = 0; j < w; j++) begin
            check(req, tick, (d != 0) && ((j % d) == d - 1));
            @(negedge clk);
        end
    endtask

    task automatic count_ticks(input int w, output int cnt);
        cnt = 0;
        for (int j = 0; j < w; j++) begin
            if (tick) cnt++;
            @(negedge clk);
        end
    endtask

    task automatic commit(input int d, input string req);
        wr(1'b0, {3'b000, 5'((d >> 8) & 31)});
        rd_check("R2 staged hidden");
        wr(1'b1, 8'(d & 255));
        run_window(d, 2 * d + 3, req);
        rd_check("R3 readback");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        int dlist [6] = '{255, 256, 1000, 4096, 6844, 8191};
        do_reset();
        // R4 reset values
        rd_check("R4 reset");
        check("R4 tick", tick, 0);
        // R5 idle before enable, even with a fresh divisor
        wr(1'b1, 8'h02);
        count_ticks(40, cnt);
        check("R5 idle", cnt, 0);
        // start with tx_en for one cycle, then drop it (R6)
        tx_en = 1'b1; @(negedge clk); tx_en = 1'b0;
        // R1 R9 R10 sweep with enables low (R6)
        for (int d = 1; d <= 24; d++) commit(d, "R9 R10 R6 phase");
        foreach (dlist[i]) commit(dlist[i], "R1 R9 period");
        // R2: staged upper bits leave rate untouched
        commit(5, "R9 d5");
        wr(1'b0, 8'h1F);
        rd_check("R2 hold");
        count_ticks(50, cnt);
        check("R2 rate", cnt, 10);
        // R3: second upper write wins, lower write alone reuses stage
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h03);
        rd_check("R3 combine");
        run_window(259, 600, "R3 period 0x103");
        wr(1'b1, 8'h07);
        rd_check("R3 restage");
        run_window(263, 600, "R3 period 0x107");
        // R7 flags and reserved bit
        wr(1'b0, 8'hFF);
        rd_check("R7 layout");
        check("R7 brk", brk_ie, 1);
        check("R7 rxe", rxe_ie, 1);
        rd_sel = 1'b0; #1;
        check("R7 rsv", rd_data[5], 0);
        wr(1'b0, 8'h40);
        check("R7 brk clr", brk_ie, 0);
        check("R7 rxe set", rxe_ie, 1);
        // R8 zero divisor
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        run_window(0, 60, "R8 zero");
        wr(1'b1, 8'h03);
        run_window(3, 20, "R8 resume");
        // R5 with rx_en alone after a fresh reset
        do_reset();
        rd_check("R4 second reset");
        wr(1'b1, 8'h03);
        count_ticks(20, cnt);
        check("R5 idle again", cnt, 0);
        rx_en = 1'b1; @(negedge clk); rx_en = 1'b0;
        wr(1'b1, 8'h04);
        run_window(4, 30, "R5 rx start");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule